// File: doc/BRIEF.md
# Reed-Solomon Codeword Expander

This block sits in front of a single error-and-erasure Reed-Solomon decoder built for the full (255,239) code over GF(2^8). Several stream formats use shortened and, in one case, punctured versions of that code. The expander takes the received bytes of one shortened codeword and rebuilds a full 255-symbol codeword, so the decoder never needs to know which format is in use. Each output symbol carries an erasure flag.

A codeword begins with an input beat that has `in_sof` set. The format select is sampled on that beat. The block first emits the zero symbols that shortening removed. It then passes the received bytes through one per accepted beat. For the punctured format, it finishes with zero placeholders flagged as erasures. Input is accepted only while received bytes are being passed through. With input held valid, the block delivers one symbol per clock, which is far above the required rate of about 8 MB/s.

Top module: `rs_cw_expander`

## Requirements
- R1: While reset is held, and afterwards with no input offered, `out_valid` is 0 and `in_ready` is 0.
- R2: Each codeword gives exactly 255 output symbols. The first has `out_sof`=1 and every other symbol has `out_sof`=0.
- R3: Format codes on `fmt_sel` select the following layouts. Code 0 gives 51 zeros then 204 received bytes. Code 1 gives 67 zeros, then 182 received bytes, then 6 placeholders. Code 2 gives 47 zeros then 208 received bytes. Code 3 behaves as code 0.
- R4: The leading fill symbols are 0x00 with `out_erase`=0. Received bytes appear unchanged, in arrival order, with `out_erase`=0.
- R5: For code 1, output positions 249 to 254 are 0x00 with `out_erase`=1. No other output position of any format has `out_erase` set.
- R6: `in_ready` is 0 while fill zeros or placeholders are emitted. The start beat waits exactly (number of fill zeros + 1) cycles before it is accepted.
- R7: Dropping `in_valid` during the received-byte phase inserts output bubbles but loses, duplicates or reorders no byte.
- R8: `fmt_sel` is sampled only on the start beat. Changing it inside a codeword does not alter that codeword's layout.
- R9: When no codeword is in progress, a beat with `in_valid`=1 and `in_sof`=0 is accepted (`in_ready`=1), discarded, and produces no output.
- R10: With `in_valid` held high, the 255 symbols of a codeword appear on 255 consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fmt_sel | input | 2 | Format code, sampled on the start beat |
| in_valid | input | 1 | Input byte valid |
| in_sof | input | 1 | Input beat is the first byte of a codeword |
| in_data | input | 8 | Received byte |
| in_ready | output | 1 | Input beat is taken this cycle |
| out_valid | output | 1 | Output symbol valid |
| out_sof | output | 1 | Output symbol is position 0 of a codeword |
| out_data | output | 8 | Output symbol |
| out_erase | output | 1 | Output symbol is a punctured placeholder |

## Verification
The assertions assume that upstream holds a start beat until it is accepted. They also assume that the output side never stalls, since the block has no output backpressure. The stimulus keeps `in_sof` and the byte steady on every beat until `in_ready` is seen. It drops `in_valid` only after the start byte has been taken. The output sequence is compared against a layout computed from the format code alone.

// File: rtl/rs_exp_pkg.sv
// Package: shared constants, types and format geometry for the codeword expander.
// Assumes a mother code of CW_LEN symbols of SYM_W bits each.
package rs_exp_pkg;
    localparam int unsigned SYM_W      = 8;
    localparam int unsigned CW_LEN     = 255;
    localparam int unsigned POS_W      = $clog2(CW_LEN + 1);
    localparam int unsigned FMT_W      = 2;
    localparam int unsigned BCAST_FILL = 51;
    localparam int unsigned ROW_FILL   = 67;
    localparam int unsigned ROW_HOLES  = 6;
    localparam int unsigned COL_FILL   = 47;

    typedef logic [POS_W-1:0] pos_t;
    typedef logic [SYM_W-1:0] sym_t;

    typedef enum logic [FMT_W-1:0] {
        FMT_BCAST = 2'd0,
        FMT_ROW   = 2'd1,
        FMT_COL   = 2'd2,
        FMT_SPARE = 2'd3
    } fmt_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_FILL = 2'd1,
        PH_BODY = 2'd2,
        PH_HOLE = 2'd3
    } phase_e;

    // Boundaries of one format's layout inside the full codeword.
    typedef struct packed {
        pos_t body_first;
        pos_t body_last;
        logic has_holes;
    } geom_t;

    // Maps a format code to its layout; the spare code falls back to broadcast.
    function automatic geom_t geom_of(input fmt_e f);
        int unsigned fill;
        int unsigned holes;
        geom_t g;
        case (f)
            FMT_ROW: begin fill = ROW_FILL;   holes = ROW_HOLES; end
            FMT_COL: begin fill = COL_FILL;   holes = 0;         end
            default: begin fill = BCAST_FILL; holes = 0;         end
        endcase
        g.body_first = pos_t'(fill);
        g.body_last  = pos_t'(CW_LEN - holes - 1);
        g.has_holes  = (holes != 0);
        return g;
    endfunction
endpackage

// File: rtl/rs_geom_latch.sv
// Module: holds the layout of the codeword in progress.
// Assumes capture pulses for one cycle on the start beat only.
module rs_geom_latch
    import rs_exp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [FMT_W-1:0] fmt_sel,
    input  logic             capture,
    input  logic             busy,
    output geom_t            geom_q
);
    // Sample the format on the start beat and hold it for the whole codeword.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            geom_q <= geom_of(FMT_BCAST);
        end else if (capture) begin
            geom_q <= geom_of(fmt_e'(fmt_sel));
        end
    end

    // R8: the layout cannot move while a codeword is being emitted.
    a_r8_geom_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !capture) |=> $stable(geom_q));
endmodule

// File: rtl/rs_seq_ctrl.sv
// Module: phase sequencer and output position counter.
// Assumes upstream holds a start beat until in_ready and never stalls the output.
module rs_seq_ctrl
    import rs_exp_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   in_valid,
    input  logic   in_sof,
    input  geom_t  geom,
    output logic   start,
    output logic   in_ready,
    output logic   emit,
    output phase_e emit_kind,
    output logic   emit_first,
    output logic   busy
);
    localparam pos_t ONE      = pos_t'(1);
    localparam pos_t LAST_POS = pos_t'(CW_LEN - 1);

    phase_e phase_q;
    pos_t   pos_q;

    // Decode the handshake and the emit strobe from the current phase.
    always_comb begin
        start      = (phase_q == PH_IDLE) && in_valid && in_sof;
        in_ready   = (phase_q == PH_BODY) ||
                     ((phase_q == PH_IDLE) && in_valid && !in_sof);
        emit       = (phase_q == PH_FILL) || (phase_q == PH_HOLE) ||
                     ((phase_q == PH_BODY) && in_valid);
        emit_kind  = phase_q;
        emit_first = (pos_q == '0);
        busy       = (phase_q != PH_IDLE);
    end

    // Advance the phase and position once per emitted symbol.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            pos_q   <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        phase_q <= PH_FILL;
                        pos_q   <= '0;
                    end
                end
                PH_FILL: begin
                    pos_q <= pos_q + ONE;
                    if (pos_q == (geom.body_first - ONE)) begin
                        phase_q <= PH_BODY;
                    end
                end
                PH_BODY: begin
                    if (in_valid) begin
                        pos_q <= pos_q + ONE;
                        if (pos_q == geom.body_last) begin
                            phase_q <= geom.has_holes ? PH_HOLE : PH_IDLE;
                        end
                    end
                end
                default: begin
                    pos_q <= pos_q + ONE;
                    if (pos_q == LAST_POS) begin
                        phase_q <= PH_IDLE;
                    end
                end
            endcase
        end
    end

    // R2: the position never runs past the last symbol of a codeword.
    a_r2_pos_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (pos_q <= LAST_POS));

    // R6: the start beat is never taken in the same cycle as it is detected.
    a_r6_start_waits: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !in_ready);
endmodule

// File: rtl/rs_out_stage.sv
// Module: output register stage for symbol, start flag and erasure flag.
// Assumes emit_kind is PH_FILL, PH_BODY or PH_HOLE whenever emit is set.
module rs_out_stage
    import rs_exp_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   emit,
    input  phase_e emit_kind,
    input  logic   emit_first,
    input  sym_t   in_data,
    output logic   out_valid,
    output logic   out_sof,
    output sym_t   out_data,
    output logic   out_erase
);
    // Register one output symbol per emit strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
            out_data  <= '0;
            out_erase <= 1'b0;
        end else begin
            out_valid <= emit;
            out_sof   <= emit && emit_first;
            out_data  <= (emit && emit_kind == PH_BODY) ? in_data : '0;
            out_erase <= emit && (emit_kind == PH_HOLE);
        end
    end

    // R5: a placeholder is always a valid zero symbol.
    a_r5_erase_zero: assert property (@(posedge clk) disable iff (!rst_n)
        out_erase |-> (out_valid && out_data == '0));

    // R5: once placeholders start, only placeholders follow until the next codeword.
    a_r5_erase_tail: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid) && $past(out_erase)) |-> (out_erase || out_sof));
endmodule

// File: rtl/rs_cw_expander.sv
// Module: top level; expands shortened and punctured codewords to full length.
// Assumes no output backpressure and a held start beat upstream.
module rs_cw_expander
    import rs_exp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [FMT_W-1:0] fmt_sel,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic [SYM_W-1:0] in_data,
    output logic             in_ready,
    output logic             out_valid,
    output logic             out_sof,
    output logic [SYM_W-1:0] out_data,
    output logic             out_erase
);
    geom_t  geom;
    logic   start;
    logic   emit;
    phase_e emit_kind;
    logic   emit_first;
    logic   busy;

    rs_geom_latch u_geom (
        .clk     (clk),
        .rst_n   (rst_n),
        .fmt_sel (fmt_sel),
        .capture (start),
        .busy    (busy),
        .geom_q  (geom)
    );

    rs_seq_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_sof     (in_sof),
        .geom       (geom),
        .start      (start),
        .in_ready   (in_ready),
        .emit       (emit),
        .emit_kind  (emit_kind),
        .emit_first (emit_first),
        .busy       (busy)
    );

    rs_out_stage u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .emit       (emit),
        .emit_kind  (emit_kind),
        .emit_first (emit_first),
        .in_data    (in_data),
        .out_valid  (out_valid),
        .out_sof    (out_sof),
        .out_data   (out_data),
        .out_erase  (out_erase)
    );

    // R7: every byte taken mid-codeword shows up as a non-erased symbol next cycle.
    a_r7_accept_emits: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && in_valid && in_ready) |=> (out_valid && !out_erase));

    // R2: a start flag only marks a valid, non-erased symbol.
    a_r2_sof_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> (out_valid && !out_erase));
endmodule

// File: tb/rs_cw_expander_tb.sv
// Bench: sweeps every format with and without input gaps and checks the layout.
module rs_cw_expander_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] fmt_sel = 2'd0;
    logic       in_valid = 1'b0;
    logic       in_sof = 1'b0;
    logic [7:0] in_data = 8'd0;
    logic       in_ready;
    logic       out_valid;
    logic       out_sof;
    logic [7:0] out_data;
    logic       out_erase;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int cap_n = 0;
    logic [7:0] cap_d [0:299];
    bit         cap_e [0:299];
    bit         cap_s [0:299];
    int         cap_c [0:299];

    always #5 clk = ~clk;

    rs_cw_expander dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .fmt_sel   (fmt_sel),
        .in_valid  (in_valid),
        .in_sof    (in_sof),
        .in_data   (in_data),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_sof   (out_sof),
        .out_data  (out_data),
        .out_erase (out_erase)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // Capture every output symbol away from the active edge.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (cap_n < 300) begin
                cap_d[cap_n] = out_data;
                cap_e[cap_n] = out_erase;
                cap_s[cap_n] = out_sof;
                cap_c[cap_n] = cyc;
            end
            cap_n = cap_n + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int fill_of(input int f);
        return (f == 1) ? 67 : (f == 2) ? 47 : 51;
    endfunction

    function automatic int holes_of(input int f);
        return (f == 1) ? 6 : 0;
    endfunction

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'((seed * 37 + i * 13 + (i >> 3)) & 255);
    endfunction

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    // Send one codeword, then compare the captured output with the computed layout.
    task automatic run_frame(input int f, input int seed, input bit gaps,
                             input int chg_at, input int chg_to);
        int fill  = fill_of(f);
        int holes = holes_of(f);
        int ncode = 255 - fill - holes;
        int i = 0;
        int stalls = 0;
        int wd = 0;
        int bad_pad = 0, bad_body = 0, bad_erase = 0, bad_sof = 0, bad_all = 0;
        bit gapped = 0;
        cap_n = 0;
        fmt_sel = 2'(f);
        while (i < ncode) begin
            @(negedge clk);
            if (chg_at >= 0 && i == chg_at) fmt_sel = 2'(chg_to);
            if (gaps && i > 0 && (i % 7 == 3) && !gapped) begin
                in_valid = 1'b0;
                gapped = 1;
            end else begin
                in_valid = 1'b1;
                in_sof = (i == 0);
                in_data = pat(seed, i);
                #1;
                if (in_ready) begin
                    i++;
                    gapped = 0;
                end else if (i == 0) begin
                    stalls++;
                end
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_sof = 1'b0;
        if (holes != 0) begin
            in_valid = 1'b1;
            in_data = 8'hA5;
            #1;
            chk(in_ready == 1'b0, "R6 ready low during placeholders", int'(in_ready), 0);
            in_valid = 1'b0;
        end
        while (cap_n < 255 && wd < 1000) begin
            @(negedge clk);
            wd++;
        end
        repeat (4) @(negedge clk);
        chk(cap_n == 255, "R2 symbol count", cap_n, 255);
        for (int k = 0; k < 255; k++) begin
            logic [7:0] ed;
            bit         ee;
            ed = (k >= fill && k < fill + ncode) ? pat(seed, k - fill) : 8'd0;
            ee = (k >= fill + ncode);
            if (cap_s[k] != (k == 0)) bad_sof++;
            if (k < fill && (cap_d[k] != 8'd0 || cap_e[k])) bad_pad++;
            if (k >= fill && k < fill + ncode && (cap_d[k] != ed || cap_e[k])) bad_body++;
            if (cap_e[k] != ee) bad_erase++;
            if (cap_d[k] != ed || cap_e[k] != ee) bad_all++;
        end
        chk(bad_sof == 0, "R2 start flag placement", bad_sof, 0);
        chk(bad_pad == 0, "R4 fill zeros", bad_pad, 0);
        chk(bad_body == 0, gaps ? "R7 gapped byte order" : "R4 byte order", bad_body, 0);
        chk(bad_erase == 0, "R5 erasure positions", bad_erase, 0);
        chk(bad_all == 0, (chg_at >= 0) ? "R8 layout kept" : "R3 layout", bad_all, 0);
        chk(stalls == fill + 1, "R6 start beat wait", stalls, fill + 1);
        if (!gaps)
            chk(cap_c[254] - cap_c[0] == 254, "R10 consecutive output",
                cap_c[254] - cap_c[0], 254);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1 no output in reset", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(out_valid == 1'b0, "R1 idle output", int'(out_valid), 0);
        chk(in_ready == 1'b0, "R1 idle ready", int'(in_ready), 0);

        // R9: stray beats while idle are taken and dropped.
        in_valid = 1'b1;
        in_sof = 1'b0;
        in_data = 8'd77;
        #1;
        chk(in_ready == 1'b1, "R9 stray beat accepted", int'(in_ready), 1);
        repeat (3) @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(cap_n == 0, "R9 stray beat silent", cap_n, 0);

        for (int f = 0; f < 4; f++) begin
            run_frame(f, f + 1, 1'b0, -1, 0);
            run_frame(f, f + 11, 1'b1, -1, 0);
        end
        run_frame(1, 5, 1'b0, 10, 2);
        run_frame(2, 9, 1'b0, 40, 1);

        summary();
        $finish;
    end
endmodule